// File: doc/BRIEF.md
# HDLC Line Idle Detector

This block watches a serial HDLC receive line and reports two kinds of idle line. Bits arrive on `bit_i`, and a bit is taken only in a cycle where `bit_vld_i` is high. Two level outputs result. `mark_idle_o` reports a line held at one for a long run of bits. `flag_idle_o` reports a line that carries only a chain of back-to-back flag octets with no data between them. Both levels feed a receive status register. The block does not remove stuffed zeros, extract frames or check a CRC.

A flag is the octet 0x7E. The detector finds it in an 8-bit window that moves by one bit on each valid bit. Two flags are contiguous when the second one completes exactly 8 valid bits after the first. The first flag of a chain closes the frame before it, so that flag does not count toward the idle run.

Top module: `hdlc_idle_detect`

## Requirements
- R1: After the 15th consecutive valid one bit, `mark_idle_o` is high from the rising edge that samples that bit. After only 14 consecutive ones it is still low.
- R2: A valid zero bit clears `mark_idle_o` at the edge that samples it.
- R3: `mark_idle_o` stays high for as long as valid one bits continue, however long the run. The run count saturates and does not wrap.
- R4: The flag pattern is 0x7E, and a byte is sent most significant bit first. After a leading flag, three more flags follow, each completing exactly 8 valid bits after the one before it. `flag_idle_o` goes high at the edge that samples the last bit of the third of these flags. After only two such flags it is still low.
- R5: A flag that completes at any spacing other than 8 valid bits after the previous flag starts a new chain as its leading flag. The same applies to the first flag after reset and to a flag that follows data. Such a flag resets the contiguous count to zero.
- R6: Eight valid bits after the last flag, if those 8 bits do not form a flag, `flag_idle_o` is cleared at the edge that samples the 8th bit. It stays high through the first 7 bits.
- R7: A cycle with `bit_vld_i` low has no effect on either output or on any count, whatever the value of `bit_i`.
- R8: Reset (`rst_ni` low) clears both outputs and all counts. Fewer than 8 bits received after reset are never recognised as a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Serial receive data bit |
| mark_idle_o | output | 1 | Line held at one for 15 or more bits |
| flag_idle_o | output | 1 | Contiguous flag chain after the leading flag |

## Verification
The assertions check the following on every cycle:
- Each output changes only on a valid bit.
- Mark idle rises only on a one and clears on any zero.
- Mark idle holds through a continuing run of ones.
- Flag idle rises only on the zero that ends a flag.
- The two idle levels are never high together.

Some behaviours depend on counting bits, and only the bench's scenarios can show them:
- The 14-versus-15 threshold for mark idle.
- The two-versus-three threshold for contiguous flags.
- The 7-versus-8 bit window that clears flag idle.
- The restart of the chain after a mis-spaced flag.
- Rejection of a partial octet after reset.

// File: rtl/hdlc_idle_pkg.sv
package hdlc_idle_pkg;
  localparam int unsigned OCTET_W      = 8;
  localparam logic [7:0]  FLAG_OCTET   = 8'h7E;
  localparam int unsigned MARK_RUN_DEF = 15;
  localparam int unsigned FLAG_RUN_DEF = 3;
endpackage

// File: rtl/hdlc_ones_run.sv
module hdlc_ones_run #(
  parameter int unsigned MARK_RUN = 15,
  localparam int unsigned CW = $clog2(MARK_RUN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic mark_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (bit_vld_i) begin
      if (!bit_i)                       cnt_q <= '0;
      else if (cnt_q != CW'(MARK_RUN))  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mark_o = (cnt_q == CW'(MARK_RUN));
endmodule

// File: rtl/hdlc_flag_match.sv
module hdlc_flag_match #(
  parameter int unsigned     OCTET_W = 8,
  parameter logic [OCTET_W-1:0] PATTERN = 8'h7E
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic hit_o
);
  logic [OCTET_W-1:0] win_q, win_d;

  assign win_d = {win_q[OCTET_W-2:0], bit_i};

  // all-ones preload: the pattern's zero bits must really arrive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        win_q <= '1;
    else if (bit_vld_i) win_q <= win_d;
  end

  assign hit_o = bit_vld_i && (win_d == PATTERN);
endmodule

// File: rtl/hdlc_flag_chain.sv
module hdlc_flag_chain #(
  parameter int unsigned OCTET_W  = 8,
  parameter int unsigned FLAG_RUN = 3,
  localparam int unsigned GW = $clog2(OCTET_W + 1),
  localparam int unsigned RW = $clog2(FLAG_RUN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic hit_i,
  output logic idle_o
);
  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q;
  logic          on_slot;

  // gap == OCTET_W means "no usable previous flag"
  assign on_slot = (gap_q == GW'(OCTET_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GW'(OCTET_W);
    end else if (bit_vld_i) begin
      if (hit_i)                        gap_q <= '0;
      else if (gap_q != GW'(OCTET_W))   gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (bit_vld_i) begin
      if (hit_i) begin
        if (!on_slot)                        run_q <= '0;
        else if (run_q != RW'(FLAG_RUN))     run_q <= run_q + 1'b1;
      end else if (on_slot) begin
        run_q <= '0;
      end
    end
  end

  assign idle_o = (run_q == RW'(FLAG_RUN));
endmodule

// File: rtl/hdlc_idle_detect.sv
module hdlc_idle_detect
  import hdlc_idle_pkg::*;
#(
  parameter int unsigned MARK_RUN = MARK_RUN_DEF,
  parameter int unsigned FLAG_RUN = FLAG_RUN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic mark_idle_o,
  output logic flag_idle_o
);
  logic flag_hit;

  hdlc_ones_run #(.MARK_RUN(MARK_RUN)) u_ones (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .mark_o(mark_idle_o)
  );

  hdlc_flag_match #(.OCTET_W(OCTET_W), .PATTERN(FLAG_OCTET)) u_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .hit_o(flag_hit)
  );

  hdlc_flag_chain #(.OCTET_W(OCTET_W), .FLAG_RUN(FLAG_RUN)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .hit_i(flag_hit),
    .idle_o(flag_idle_o)
  );
endmodule

// File: rtl/hdlc_idle_detect_chk.sv
module hdlc_idle_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_vld_i,
  input logic bit_i,
  input logic mark_idle_o,
  input logic flag_idle_o
);
  AST_MARK_RISE_ON_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mark_idle_o) |-> $past(bit_vld_i && bit_i)); // R1
  AST_MARK_CLR_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && !bit_i) |=> !mark_idle_o); // R2
  AST_MARK_HOLD_ON_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_idle_o && bit_vld_i && bit_i) |=> mark_idle_o); // R3
  AST_FLAG_RISE_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_idle_o) |-> $past(bit_vld_i && !bit_i)); // R4
  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mark_idle_o && flag_idle_o)); // R6
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> ($stable(mark_idle_o) && $stable(flag_idle_o))); // R7
endmodule

bind hdlc_idle_detect hdlc_idle_detect_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
  .mark_idle_o(mark_idle_o), .flag_idle_o(flag_idle_o)
);

// File: tb/tb_hdlc_idle_detect.sv
`timescale 1ns/1ps
module tb_hdlc_idle_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic din = 1'b0;
  logic mark_o, flag_o;
  int   n_chk = 0;
  int   n_err = 0;

  always #4 clk = ~clk;

  hdlc_idle_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(vld), .bit_i(din),
    .mark_idle_o(mark_o), .flag_idle_o(flag_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b0; din = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    vld = 1'b1; din = b;
    @(posedge clk); #1;
    vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic idle_cycles(input int n, input logic b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vld = 1'b0; din = b;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk("R8 mark after reset", mark_o, 1'b0);
    chk("R8 flag after reset", flag_o, 1'b0);
  endtask

  task automatic t_mark_run();
    do_reset();
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    chk("R1 mark after 14 ones", mark_o, 1'b0);
    send_bit(1'b1);
    chk("R1 mark after 15 ones", mark_o, 1'b1);
    for (int i = 0; i < 40; i++) send_bit(1'b1);
    chk("R3 mark held after long run", mark_o, 1'b1);
    send_bit(1'b0);
    chk("R2 mark cleared by zero", mark_o, 1'b0);
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    chk("R2 count restarted after zero", mark_o, 1'b0);
  endtask

  task automatic t_strobe_gating();
    do_reset();
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    idle_cycles(6, 1'b0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    chk("R7 invalid zeros ignored, 14 ones", mark_o, 1'b0);
    send_bit(1'b1);
    chk("R7 mark after 15 valid ones", mark_o, 1'b1);
    idle_cycles(5, 1'b0);
    #1;
    chk("R7 mark held over invalid zeros", mark_o, 1'b1);
  endtask

  task automatic t_flag_chain();
    do_reset();
    send_byte(8'h00);
    send_byte(8'h7E);
    send_byte(8'h7E);
    send_byte(8'h7E);
    chk("R4 flag idle after two extra flags", flag_o, 1'b0);
    send_byte(8'h7E);
    chk("R4 flag idle after three extra flags", flag_o, 1'b1);
    send_byte(8'h7E);
    chk("R4 flag idle held", flag_o, 1'b1);
    for (int i = 7; i >= 1; i--) send_bit(1'b0);
    chk("R6 flag idle held through 7 bits", flag_o, 1'b1);
    send_bit(1'b0);
    chk("R6 flag idle cleared on 8th bit", flag_o, 1'b0);
  endtask

  task automatic t_flag_spacing();
    do_reset();
    send_byte(8'h7E);
    send_byte(8'h7E);
    send_byte(8'h7E);
    send_bit(1'b0);
    send_byte(8'h7E);
    send_byte(8'h7E);
    send_byte(8'h7E);
    chk("R5 mis-spaced flag restarts chain", flag_o, 1'b0);
    send_byte(8'h7E);
    chk("R5 chain completes after restart", flag_o, 1'b1);
  endtask

  task automatic t_partial_after_reset();
    do_reset();
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_byte(8'h7E);
    send_byte(8'h7E);
    send_byte(8'h7E);
    chk("R8 partial octet not a flag", flag_o, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_mark_run();
    t_strobe_gating();
    t_flag_chain();
    t_flag_spacing();
    t_partial_after_reset();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule